// File: doc/BRIEF.md
# Front-End Default Register Loader

After power-up and after every board reset, this block programs two analog front-end chips with a fixed set of default register values. The two chips share one serial clock line and one serial data line. Each chip has its own load strobe, so each chip can be given different settings. The default values arrive as two parameter tables, one per chip. Each table entry holds a 3-bit register address and an 11-bit data value.

The loader works through the first chip's table and then the second chip's table, both in entry order. For every entry it builds a 16-bit write word and shifts it out bit by bit while that chip's strobe is held high. A serial clock is derived from the system clock by a parameter. When the last word has been written, `done` rises. From then on the block passes the host router's serial lines straight through to its outputs. Until `done` rises, the loader owns the lines and the host inputs are ignored.

Top module: `afe_boot_loader`

## Requirements
- R1: While `rst_n` is low, `done`, `afe_ld` and `sclk` are all 0.
- R2: The words go out as all NUM_REGS entries of the chip-1 table under `afe_ld` = 2'b01, then all entries of the chip-2 table under `afe_ld` = 2'b10, each table from entry 0 upward. Entry i of a table sits at bits [14i+13:14i], with the address in the top 3 bits and the data in the low 11 bits.
- R3: Each word is sent in this order: first a read/write flag of 0 (write), then address bits A0, A1, A2, then a test bit of 0, then data bits D0 up to D10.
- R4: `sclk` idles low. Each high phase lasts exactly CLK_DIV system cycles. `sdata` never changes while `sclk` is high, so it changes only on or after a falling edge.
- R5: A strobe goes high and falls only while `sclk` is low. It stays high across exactly 16 rising edges of `sclk`. At most one strobe is high at a time.
- R6: Between words, and between reset release and the first word, `afe_ld` stays all-low for at least 2·GAP_BITS·CLK_DIV system cycles. GAP_BITS is at least 2, so this gap is at least two serial clock periods.
- R7: `done` first reads 1 exactly 2·NUM_REGS·(2·GAP_BITS+32)·CLK_DIV clock edges after reset release. It then stays 1 until the next reset.
- R8: While `done` is 0, the host inputs have no effect: `sclk` and `sdata` are 0 whenever no strobe is high. Once `done` is 1, `sclk`, `sdata` and `afe_ld` equal `host_sclk`, `host_sdata` and `host_ld`.
- R9: A reset at any point, including in the middle of a word, abandons the current transfer and restarts the whole sequence from chip-1 entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up / board reset, asynchronous |
| host_sclk | input | 1 | Serial clock from the host router |
| host_sdata | input | 1 | Serial data from the host router |
| host_ld | input | 2 | Load strobes from the host router |
| sclk | output | 1 | Shared serial clock to both front-ends |
| sdata | output | 1 | Shared serial data to both front-ends |
| afe_ld | output | 2 | Load strobes: bit 0 for chip 1, bit 1 for chip 2 |
| done | output | 1 | Default programming finished; host owns the lines |

## Verification
Faults in different parts of the block show up at the ports in different ways:
- A corrupted word-index counter, or one that wraps early, sends a word to the wrong chip or out of order. It also moves the rise of `done` away from its predicted cycle.
- A shifter that is off by one position garbles the address and data fields of the very first word. This is visible about 40 cycles after reset.
- A faulty phase or bit counter shows up within one serial period as a wrong count of clock pulses per strobe, a wrong high-phase length, or a short gap between strobes.
- A fault in the passthrough mux shows as host activity leaking onto the lines during the boot sequence, or being blocked after `done`.

// File: rtl/afe_boot_pkg.sv
package afe_boot_pkg;

  localparam int AW      = 3;
  localparam int DW      = 11;
  localparam int ENTRY_W = AW + DW;
  localparam int WORD_W  = 2 + AW + DW;

  localparam logic RW_WRITE = 1'b0;
  localparam logic TEST_VAL = 1'b0;

  typedef enum logic [1:0] {
    S_GAP   = 2'd0,
    S_SHIFT = 2'd1,
    S_DONE  = 2'd2
  } seq_state_e;

  // Bit k of the result is the k-th bit on the wire.
  function automatic logic [WORD_W-1:0] make_word(input logic [AW-1:0] a,
                                                  input logic [DW-1:0] d);
    return {d, TEST_VAL, a, RW_WRITE};
  endfunction

  function automatic logic [AW-1:0] entry_addr(input logic [ENTRY_W-1:0] e);
    return e[ENTRY_W-1 -: AW];
  endfunction

  function automatic logic [DW-1:0] entry_data(input logic [ENTRY_W-1:0] e);
    return e[DW-1:0];
  endfunction

endpackage

// File: rtl/afe_boot_tick.sv
module afe_boot_tick #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (tick) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/afe_boot_shifter.sv
module afe_boot_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         bit_out
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh <= '0;
    else if (load)   sh <= load_word;
    else if (shift)  sh <= {1'b0, sh[W-1:1]};
  end

  assign bit_out = sh[0];
endmodule

// File: rtl/afe_boot_seq.sv
module afe_boot_seq
  import afe_boot_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int GAP_TICKS = 4,
  parameter int WLEN      = 16,
  localparam int IDX_W    = $clog2(NUM_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic             load_req,
  output logic             shift_req,
  output logic             word_end,
  output logic             strobe,
  output logic             sclk_int,
  output logic [IDX_W-1:0] widx,
  output logic             done
);
  localparam int GW = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam int BW = $clog2(WLEN);

  seq_state_e    state;
  logic [GW-1:0] gap_cnt;
  logic [BW-1:0] bit_cnt;
  logic          gap_last, bit_last, in_shift;

  assign in_shift  = (state == S_SHIFT);
  assign gap_last  = (gap_cnt == GW'(GAP_TICKS - 1));
  assign bit_last  = (bit_cnt == BW'(WLEN - 1));
  assign load_req  = tick && (state == S_GAP) && gap_last;
  assign word_end  = tick && in_shift && sclk_int && bit_last;
  assign shift_req = tick && in_shift && sclk_int && !bit_last;
  assign done      = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_GAP;
      gap_cnt  <= '0;
      bit_cnt  <= '0;
      strobe   <= 1'b0;
      sclk_int <= 1'b0;
      widx     <= '0;
    end else if (tick) begin
      unique case (state)
        S_GAP: begin
          if (gap_last) begin
            gap_cnt <= '0;
            strobe  <= 1'b1;
            state   <= S_SHIFT;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_SHIFT: begin
          if (!sclk_int) begin
            sclk_int <= 1'b1;
          end else begin
            sclk_int <= 1'b0;
            if (bit_last) begin
              bit_cnt <= '0;
              strobe  <= 1'b0;
              widx    <= widx + 1'b1;
              state   <= (widx == IDX_W'(NUM_WORDS - 1)) ? S_DONE : S_GAP;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end
endmodule

// File: rtl/afe_boot_loader.sv
module afe_boot_loader
  import afe_boot_pkg::*;
#(
  parameter int CLK_DIV  = 2,
  parameter int GAP_BITS = 2,
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*ENTRY_W-1:0] AFE1_TABLE =
    {3'd3, 11'h0A5, 3'd2, 11'h1F0, 3'd1, 11'h400, 3'd0, 11'h05A},
  parameter logic [NUM_REGS*ENTRY_W-1:0] AFE2_TABLE =
    {3'd7, 11'h3C3, 3'd6, 11'h012, 3'd5, 11'h7FF, 3'd4, 11'h100}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sclk,
  input  logic       host_sdata,
  input  logic [1:0] host_ld,
  output logic       sclk,
  output logic       sdata,
  output logic [1:0] afe_ld,
  output logic       done
);
  localparam int NUM_WORDS = 2 * NUM_REGS;
  localparam int GAP_TICKS = 2 * GAP_BITS;
  localparam int IDX_W     = $clog2(NUM_WORDS + 1);

  logic [WORD_W-1:0] word_rom [NUM_WORDS];
  logic [WORD_W-1:0] cur_word;
  logic              tick, load_req, shift_req, word_end, strobe, sclk_int;
  logic              bit_out, dev2_sel, boot_done;
  logic [IDX_W-1:0]  widx;
  logic [1:0]        ld_int;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_rom
    assign word_rom[i] = make_word(entry_addr(AFE1_TABLE[i*ENTRY_W +: ENTRY_W]),
                                   entry_data(AFE1_TABLE[i*ENTRY_W +: ENTRY_W]));
    assign word_rom[NUM_REGS+i] = make_word(entry_addr(AFE2_TABLE[i*ENTRY_W +: ENTRY_W]),
                                            entry_data(AFE2_TABLE[i*ENTRY_W +: ENTRY_W]));
  end

  always_comb begin
    cur_word = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (widx == IDX_W'(i)) cur_word = word_rom[i];
  end

  afe_boot_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(!boot_done), .tick(tick)
  );

  afe_boot_seq #(.NUM_WORDS(NUM_WORDS), .GAP_TICKS(GAP_TICKS), .WLEN(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_req(load_req),
    .shift_req(shift_req), .word_end(word_end), .strobe(strobe),
    .sclk_int(sclk_int), .widx(widx), .done(boot_done)
  );

  afe_boot_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_req), .load_word(cur_word),
    .shift(shift_req), .bit_out(bit_out)
  );

  assign dev2_sel = (widx >= IDX_W'(NUM_REGS));
  assign ld_int   = {strobe && dev2_sel, strobe && !dev2_sel};

  assign done   = boot_done;
  assign sclk   = boot_done ? host_sclk  : sclk_int;
  assign sdata  = boot_done ? host_sdata : (strobe && bit_out);
  assign afe_ld = boot_done ? host_ld    : ld_int;
endmodule

// File: rtl/afe_boot_loader_chk.sv
module afe_boot_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       sdata,
  input logic [1:0] afe_ld,
  input logic       done,
  input logic       word_end
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $onehot0(afe_ld)) else $error("one strobe"); // R5

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && sclk && $past(sclk)) |-> $stable(sdata)) else $error("data moved"); // R4

  AST_STROBE_RISE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $rose(|afe_ld)) |-> !sclk) else $error("strobe rise"); // R5

  AST_STROBE_FALL_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $fell(|afe_ld)) |-> !sclk) else $error("strobe fall"); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done) else $error("done dropped"); // R7

  AST_WORD_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && !done) |=> (done || afe_ld == 2'b00)) else $error("strobe held"); // R6
endmodule

bind afe_boot_loader afe_boot_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
  .afe_ld(afe_ld), .done(done), .word_end(word_end)
);

// File: tb/afe_boot_loader_test.sv
module afe_boot_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 2;
  localparam int G  = 2;
  localparam int N  = 3;
  localparam logic [N*14-1:0] T1 = {3'd7, 11'h000, 3'd5, 11'h2AA, 3'd0, 11'h7FF};
  localparam logic [N*14-1:0] T2 = {3'd4, 11'h001, 3'd6, 11'h555, 3'd3, 11'h400};
  localparam int BOOT_CYC = 2 * N * (2 * G + 32) * D;

  logic clk = 0, rst_n = 0;
  logic host_sclk = 0, host_sdata = 0;
  logic [1:0] host_ld = 0;
  logic sclk, sdata, done;
  logic [1:0] afe_ld;

  int n_vec = 0, n_bad = 0;

  afe_boot_loader #(.CLK_DIV(D), .GAP_BITS(G), .NUM_REGS(N),
                    .AFE1_TABLE(T1), .AFE2_TABLE(T2)) uut (
    .clk(clk), .rst_n(rst_n), .host_sclk(host_sclk), .host_sdata(host_sdata),
    .host_ld(host_ld), .sclk(sclk), .sdata(sdata), .afe_ld(afe_ld), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected wire word for stream index k (R2, R3).
  function automatic logic [15:0] exp_word(input int k);
    logic [13:0] e;
    logic [15:0] w;
    e = (k < N) ? T1[(k % N)*14 +: 14] : T2[(k % N)*14 +: 14];
    w = '0;
    w[0] = 1'b0;                                  // write flag
    for (int b = 0; b < 3; b++)  w[1+b] = e[11+b]; // A0..A2
    w[4] = 1'b0;                                  // test bit
    for (int b = 0; b < 11; b++) w[5+b] = e[b];   // D0..D10
    return w;
  endfunction

  // Host router noise, constrained random.
  initial begin
    void'($urandom(32'd4711));
    forever begin
      @(negedge clk);
      host_sclk  = 1'($urandom % 2);
      host_sdata = 1'($urandom % 2);
      host_ld    = 2'($urandom % 4);
    end
  end

  // Front-end receiver model.
  int widx, nbits, gap, hi_cnt;
  logic [15:0] cap;
  logic [1:0] prev_ld;
  logic prev_sclk;
  always @(negedge clk) begin
    if (!rst_n) begin
      widx = 0; nbits = 0; gap = 1; hi_cnt = 0; cap = '0;
      prev_ld = 2'b00; prev_sclk = 1'b0;
    end else begin
      if (!done) begin
        if (prev_ld == 2'b00 && afe_ld != 2'b00) begin
          chk(gap >= 2 * G * D, "R6 gap", gap, 2 * G * D);
          chk(afe_ld == ((widx < N) ? 2'b01 : 2'b10), "R2 strobe", afe_ld,
              (widx < N) ? 2'b01 : 2'b10);
          nbits = 0; cap = '0;
        end
        if (afe_ld == 2'b00) begin
          gap++;
          chk(sclk == 1'b0 && sdata == 1'b0, "R8 idle lines", {sclk, sdata}, 0);
        end
        if (sclk && !prev_sclk && afe_ld != 2'b00) begin
          if (nbits < 16) cap[nbits] = sdata;
          nbits++;
        end
        if (sclk) hi_cnt++;
        else if (prev_sclk) begin
          chk(hi_cnt == D, "R4 high phase", hi_cnt, D);
          hi_cnt = 0;
        end
      end
      if (prev_ld != 2'b00 && (done || afe_ld == 2'b00)) begin
        chk(nbits == 16, "R5 bit count", nbits, 16);
        chk(cap == exp_word(widx), "R3 word", cap, exp_word(widx));
        widx++; gap = 1;
      end
      prev_ld   = done ? 2'b00 : afe_ld;
      prev_sclk = done ? 1'b0 : sclk;
    end
  end

  task automatic boot_and_time();
    int cyc;
    cyc = 0;
    @(negedge clk); rst_n = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk); cyc++;
    end
    chk(cyc == BOOT_CYC, "R7 done time", cyc, BOOT_CYC);
    #1;
    chk(widx == 2 * N, "R2 word total", widx, 2 * N);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(done == 0 && afe_ld == 0 && sclk == 0, "R1 reset state",
        {done, afe_ld, sclk}, 0);
    boot_and_time();
    // Passthrough and stickiness after done.
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      chk(sclk == host_sclk && sdata == host_sdata && afe_ld == host_ld,
          "R8 passthrough", {sclk, sdata, afe_ld}, {host_sclk, host_sdata, host_ld});
      chk(done == 1, "R7 done sticky", done, 1);
    end
    // Reset in the middle of a word.
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    repeat (100 + ($urandom % 50)) @(negedge clk);
    rst_n = 0;
    #1;
    chk(done == 0 && afe_ld == 0 && sclk == 0, "R1 R9 mid-run reset",
        {done, afe_ld, sclk}, 0);
    repeat (2) @(negedge clk);
    boot_and_time();
    chk(widx == 2 * N, "R9 restart from entry 0", widx, 2 * N);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule